// File: doc/BRIEF.md
# Subtract-Based Operand Comparator

This block compares two W-bit operands, A and B, in a single combinational path. It forms the difference B - A with one adder: A is inverted and a carry-in of one is applied. From that difference it produces four condition flags:

- C, the carry out.
- Z, set when the difference is zero.
- N, the result sign.
- V, signed overflow.

Every magnitude relation, signed or unsigned, is decoded from these flags. There is no separate comparator for each relation.

Alongside the flags, the block has three detectors. Two look at operand A alone and report whether it is all zeros or all ones. The third is an equality detect over the bitwise XNOR of A and B, which does not pass through the adder. A datapath uses the flags where it needs condition codes, and the relation outputs where it needs a direct select or a branch decision. All relations are stated as "B relative to A".

Top module: `cmp_flags`

## Requirements
- R1: `c_o` is the carry out of B + ~A + 1 at width W; it is 1 exactly when B >= A as unsigned numbers.
- R2: `z_o` is 1 exactly when every bit of B - A (mod 2^W) is zero, i.e. when A equals B.
- R3: `n_o` equals bit W-1 of B - A (mod 2^W).
- R4: `v_o` is 1 exactly when bit W-1 of A differs from bit W-1 of B and bit W-1 of the difference differs from bit W-1 of B.
- R5: `ult_o` is 1 exactly when B < A unsigned; `uge_o` is 1 exactly when B >= A unsigned.
- R6: `ule_o` is 1 exactly when B <= A unsigned (C clear or Z set); `ugt_o` is 1 exactly when B > A unsigned (C set and Z clear).
- R7: `slt_o` is 1 exactly when B < A in two's complement (N xor V); `sge_o` is its complement.
- R8: `a_zero_o` is 1 exactly when every bit of A is 0.
- R9: `a_ones_o` is 1 exactly when every bit of A is 1.
- R10: `xeq_o` is 1 exactly when A equals B. It is formed from the bitwise XNOR of the operands, not from the adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A (subtrahend) |
| b_i | input | W | Operand B (minuend) |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| ult_o | output | 1 | B < A unsigned |
| uge_o | output | 1 | B >= A unsigned |
| ule_o | output | 1 | B <= A unsigned |
| ugt_o | output | 1 | B > A unsigned |
| slt_o | output | 1 | B < A signed |
| sge_o | output | 1 | B >= A signed |
| a_zero_o | output | 1 | A is all zeros |
| a_ones_o | output | 1 | A is all ones |
| xeq_o | output | 1 | A equals B, bitwise detect |

## Verification
The bench targets operand pairs where the signed and unsigned orderings disagree. Examples are the most negative value against zero and against the most positive value. A design that tests only N, or that uses the carry as a borrow with the wrong polarity, gives the wrong answer on exactly those pairs. Equal operands are checked at zero, at all ones and at the sign boundary, so that a greater-than that forgets to exclude Z, or an overflow term taken against the wrong operand, shows up as a wrong flag. Random pairs that share their upper bits exercise long carry chains, where a broken ripple stage flips C and Z.

// File: rtl/cmp_flags.sv
module cmp_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         c_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o,
  output logic         ult_o,
  output logic         uge_o,
  output logic         ule_o,
  output logic         ugt_o,
  output logic         slt_o,
  output logic         sge_o,
  output logic         a_zero_o,
  output logic         a_ones_o,
  output logic         xeq_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] na;
  logic [W-1:0] diff;
  logic [W:0]   cy;
  logic [W-1:0] same;

  assign na    = ~a_i;
  assign cy[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign diff[i]  = b_i[i] ^ na[i] ^ cy[i];
    assign cy[i+1]  = (b_i[i] & na[i]) | (cy[i] & (b_i[i] ^ na[i]));
    assign same[i]  = ~(a_i[i] ^ b_i[i]);
  end

  assign c_o = cy[W];
  assign z_o = ~|diff;
  assign n_o = diff[MSB];
  assign v_o = (a_i[MSB] ^ b_i[MSB]) & (diff[MSB] ^ b_i[MSB]);

  assign ult_o = ~c_o;
  assign uge_o = c_o;
  assign ule_o = ~c_o | z_o;
  assign ugt_o = c_o & ~z_o;
  assign slt_o = n_o ^ v_o;
  assign sge_o = ~slt_o;

  assign a_zero_o = ~|a_i;
  assign a_ones_o = &a_i;
  assign xeq_o    = &same;

  always_comb begin
    a_r10_xeq_vs_zero: assert (xeq_o == z_o)
      else $error("xeq and zero flag disagree");
    a_r8_zero_ones_excl: assert (!(a_zero_o && a_ones_o))
      else $error("A both all-zero and all-one");
    a_r6_gt_implies_ge: assert (!ugt_o || uge_o)
      else $error("unsigned gt without ge");
    a_r7_eq_not_slt: assert (!z_o || (sge_o && !slt_o))
      else $error("equal operands reported signed less-than");
    a_r1_eq_sets_carry: assert (!z_o || c_o)
      else $error("equal operands without carry");
    a_r4_same_sign_no_v: assert ((a_i[MSB] != b_i[MSB]) || !v_o)
      else $error("overflow with same-sign operands");
  end
endmodule

// File: tb/test_cmp_flags.sv
module test_cmp_flags;
  localparam int W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b;
  logic c, z, n, v, ult, uge, ule, ugt, slt, sge, az, ao, xe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  cmp_flags #(.W(W)) i_cmp_flags (
    .a_i(a), .b_i(b), .c_o(c), .z_o(z), .n_o(n), .v_o(v),
    .ult_o(ult), .uge_o(uge), .ule_o(ule), .ugt_o(ugt),
    .slt_o(slt), .sge_o(sge), .a_zero_o(az), .a_ones_o(ao), .xeq_o(xe)
  );

  task automatic chk(input bit got, input bit exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h got=%0b exp=%0b", req, a, b, got, exp);
    end
  endtask

  function automatic bit ref_v(input logic [W-1:0] aa, input logic [W-1:0] bb);
    logic [W-1:0] d;
    d = bb - aa;
    return (aa[W-1] != bb[W-1]) && (d[W-1] != bb[W-1]);
  endfunction

  task automatic apply(input logic [W-1:0] aa, input logic [W-1:0] bb);
    logic [W-1:0] d;
    @(posedge clk);
    a = aa;
    b = bb;
    @(negedge clk);
    d = bb - aa;
    chk(c,   $unsigned(bb) >= $unsigned(aa), "R1");
    chk(z,   bb == aa, "R2");
    chk(n,   d[W-1], "R3");
    chk(v,   ref_v(aa, bb), "R4");
    chk(ult, $unsigned(bb) <  $unsigned(aa), "R5");
    chk(uge, $unsigned(bb) >= $unsigned(aa), "R5");
    chk(ule, $unsigned(bb) <= $unsigned(aa), "R6");
    chk(ugt, $unsigned(bb) >  $unsigned(aa), "R6");
    chk(slt, $signed(bb) <  $signed(aa), "R7");
    chk(sge, $signed(bb) >= $signed(aa), "R7");
    chk(az,  aa == '0, "R8");
    chk(ao,  aa == '1, "R9");
    chk(xe,  aa == bb, "R10");
  endtask

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  initial begin
    a = '0;
    b = '0;
    apply('0, '0);
    apply('1, '1);
    apply(MINV, MINV);
    apply(MINV, '0);
    apply('0, MINV);
    apply(MINV, MAXV);
    apply(MAXV, MINV);
    apply('1, '0);
    apply('0, '1);
    apply(32'd1, MINV);
    apply(MINV, 32'd1);
    apply(32'd5, 32'd12);
    apply(32'd12, 32'd5);
    void'($urandom(32'h1234abcd));
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      case (k % 4)
        1: rb = ra;
        2: rb = ra ^ (32'h1 << (k % W));
        3: rb = {ra[W-1:8], rb[7:0]};
        default: ;
      endcase
      apply(ra, rb);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule